// File: doc/BRIEF.md
# Per-Port In-Order Result Dispatcher

This block hands results held in a circular queue back to the consumers that asked for them. Each queue slot carries an occupancy flag, a flag saying its result is ready, the integer number of the consumer port it belongs to, and the result word itself. The queue's oldest slot is marked by a one-hot head vector. For every port, the block looks at the occupied slots bound to that port. It picks the one nearest the head, walking upward and wrapping. It offers that slot's result on the port with a valid/ready handshake.

Results for one port therefore leave in queue order. If the oldest slot for a port has no result yet, that port stalls, even when a younger slot for the same port is already complete. When a port accepts a result, the block raises a clear strobe for the slot that supplied it. The surrounding queue uses that strobe to free the slot and to move its head. The block holds no state: every output is a function of the inputs in the same cycle.

Top module: `qpd_dispatch`

## Requirements
- R1: A slot's port field k, read as an unsigned integer, binds the slot to port k when k is below the port count. A field value at or above the port count binds the slot to no port, so it never drives a port and is never cleared.
- R2: A slot whose occupancy flag is low is never selected, never drives a port and is never cleared.
- R3: With the head at slot h, the slot selected for port p is the occupied slot bound to p whose distance (e - h) mod NE is smallest. Slots at or above h therefore rank before slots below h.
- R4: Each port's data output equals the word of its selected slot. A port with no selected slot drives all zeros.
- R5: A port's valid output is high exactly when it has a selected slot and that slot's ready flag is high. A younger slot with a ready result is never offered in its place.
- R6: Slot e's clear strobe is high exactly when e is the selected slot of its port, that port's valid output is high, and that port's ready input is high. At most one slot is cleared per port.
- R7: All outputs follow the inputs within the same cycle. No clock or stored state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ent_alloc_i | input | NE | Per-slot occupancy flag |
| ent_pvalid_i | input | NE | Per-slot result-ready flag |
| ent_port_i | input | NE*IW | Per-slot port number, slot e at bits [e*IW +: IW] |
| ent_data_i | input | NE*W | Per-slot result word, slot e at bits [e*W +: W] |
| head_oh_i | input | NE | One-hot marker of the oldest slot |
| prt_ready_i | input | NP | Per-port accept signal |
| prt_data_o | output | NP*W | Per-port result word, port p at bits [p*W +: W] |
| prt_valid_o | output | NP | Per-port result offered |
| ent_clear_o | output | NE | Per-slot strobe: result taken this cycle |

## Verification
The assertions take the head vector to be one-hot. A head of all zeros is treated as slot 0, but nothing checks that case against the order rule. Nothing else is assumed: occupancy, ready flags, port numbers (including out-of-range values) and consumer acceptance may take any combination. The random stimulus always draws a single head position and leaves every other field free. This keeps it inside the one assumption while it reaches out-of-range ports, wraps around the head, and stalls on incomplete oldest slots.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

  // Width of a port-number field; never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/qpd_entry_decode.sv
// Turns one slot's port number into a candidate row, gated by occupancy.
module qpd_entry_decode #(
  parameter int NP = 3,
  parameter int IW = 2
) (
  input  logic          alloc_i,
  input  logic [IW-1:0] port_i,
  output logic [NP-1:0] cand_o
);

  // Out-of-range numbers match no port and give an empty row.
  function automatic logic [NP-1:0] to_onehot(input logic [IW-1:0] k);
    logic [NP-1:0] v;
    v = '0;
    for (int p = 0; p < NP; p++) begin
      if (k == IW'(p)) v[p] = 1'b1;
    end
    return v;
  endfunction

  assign cand_o = alloc_i ? to_onehot(port_i) : '0;

endmodule

// File: rtl/qpd_oldest_pick.sv
// Chooses the candidate closest to the head, walking upward with wraparound.
module qpd_oldest_pick #(
  parameter int NE = 8
) (
  input  logic [NE-1:0] req_i,
  input  logic [NE-1:0] head_oh_i,
  output logic [NE-1:0] grant_o
);

  // Lowest set bit only.
  function automatic logic [NE-1:0] lowest(input logic [NE-1:0] v);
    logic [NE-1:0] r;
    logic          seen;
    r    = '0;
    seen = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (v[i] && !seen) begin
        r[i] = 1'b1;
        seen = 1'b1;
      end
    end
    return r;
  endfunction

  // Bits at and above the head position.
  function automatic logic [NE-1:0] from_head(input logic [NE-1:0] h);
    logic [NE-1:0] m;
    logic          acc;
    acc = 1'b0;
    for (int i = 0; i < NE; i++) begin
      acc  = acc | h[i];
      m[i] = acc;
    end
    return m;
  endfunction

  logic [NE-1:0] upper_req;

  always_comb begin
    upper_req = req_i & from_head(head_oh_i);
    grant_o   = (|upper_req) ? lowest(upper_req) : lowest(req_i);
  end

  always_comb begin
    p_grant_in_req_r3: assert ((grant_o & ~req_i) == '0)
      else $error("grant outside request set");
    p_grant_single_r3: assert ($onehot0(grant_o))
      else $error("more than one grant");
    p_grant_live_r3: assert (req_i == '0 || grant_o != '0)
      else $error("requests present but no grant");
  end

endmodule

// File: rtl/qpd_port_drive.sv
// Per-port result mux and valid/ready handshake.
module qpd_port_drive #(
  parameter int NE = 8,
  parameter int W  = 8
) (
  input  logic [NE-1:0]   grant_i,
  input  logic [NE-1:0]   pvalid_i,
  input  logic [NE*W-1:0] data_i,
  input  logic            ready_i,
  output logic [W-1:0]    data_o,
  output logic            valid_o,
  output logic [NE-1:0]   xfer_o
);

  logic [NE-1:0] live_grant;

  always_comb begin
    data_o = '0;
    for (int e = 0; e < NE; e++) begin
      data_o = data_o | (data_i[e*W +: W] & {W{grant_i[e]}});
    end
    live_grant = grant_i & pvalid_i;
    valid_o    = |live_grant;
    xfer_o     = (valid_o && ready_i) ? live_grant : '0;
  end

  always_comb begin
    p_xfer_needs_ready_r6: assert (xfer_o == '0 || ready_i)
      else $error("transfer without ready");
  end

endmodule

// File: rtl/qpd_dispatch.sv
module qpd_dispatch #(
  parameter int NP = 3,
  parameter int NE = 8,
  parameter int W  = 8,
  parameter int IW = qpd_pkg::idx_w(NP)
) (
  input  logic [NE-1:0]    ent_alloc_i,
  input  logic [NE-1:0]    ent_pvalid_i,
  input  logic [NE*IW-1:0] ent_port_i,
  input  logic [NE*W-1:0]  ent_data_i,
  input  logic [NE-1:0]    head_oh_i,
  input  logic [NP-1:0]    prt_ready_i,
  output logic [NP*W-1:0]  prt_data_o,
  output logic [NP-1:0]    prt_valid_o,
  output logic [NE-1:0]    ent_clear_o
);

  logic [NE-1:0][NP-1:0] cand_row;
  logic [NP-1:0][NE-1:0] cand_col;
  logic [NP-1:0][NE-1:0] win_col;
  logic [NP-1:0][NE-1:0] xfer_col;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    qpd_entry_decode #(.NP(NP), .IW(IW)) u_dec (
      .alloc_i (ent_alloc_i[e]),
      .port_i  (ent_port_i[e*IW +: IW]),
      .cand_o  (cand_row[e])
    );
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < NE; e++) begin
        cand_col[p][e] = cand_row[e][p];
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_prt
    qpd_oldest_pick #(.NE(NE)) u_pick (
      .req_i     (cand_col[p]),
      .head_oh_i (head_oh_i),
      .grant_o   (win_col[p])
    );
    qpd_port_drive #(.NE(NE), .W(W)) u_drv (
      .grant_i  (win_col[p]),
      .pvalid_i (ent_pvalid_i),
      .data_i   (ent_data_i),
      .ready_i  (prt_ready_i[p]),
      .data_o   (prt_data_o[p*W +: W]),
      .valid_o  (prt_valid_o[p]),
      .xfer_o   (xfer_col[p])
    );
  end

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      ent_clear_o[e] = 1'b0;
      for (int p = 0; p < NP; p++) begin
        ent_clear_o[e] = ent_clear_o[e] | xfer_col[p][e];
      end
    end
  end

  // Cross-module checks
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      p_winner_alloc_r2: assert ((win_col[p] & ~ent_alloc_i) == '0)
        else $error("unoccupied slot selected");
      p_idle_zero_r4: assert (win_col[p] != '0 || prt_data_o[p*W +: W] == '0)
        else $error("idle port drives nonzero data");
      p_valid_from_winner_r5: assert (!prt_valid_o[p] || (win_col[p] & ent_pvalid_i) != '0)
        else $error("valid without ready winner");
      p_one_clear_per_port_r6: assert ($countones(xfer_col[p]) <= 1)
        else $error("several slots cleared for one port");
    end
    for (int e = 0; e < NE; e++) begin
      logic hs_ok;
      hs_ok = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (ent_port_i[e*IW +: IW] == IW'(p) && prt_ready_i[p] && prt_valid_o[p]) hs_ok = 1'b1;
      end
      p_clear_handshake_r6: assert (!ent_clear_o[e] || (ent_alloc_i[e] && ent_pvalid_i[e] && hs_ok))
        else $error("clear without completed handshake");
    end
  end

endmodule

// File: tb/tb_qpd_dispatch.sv
module tb_qpd_dispatch;
  localparam int NP = 3;
  localparam int NE = 8;
  localparam int W  = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NE-1:0]    alloc_v, pval_v, head_v, clear_o;
  logic [NE*IW-1:0] port_v;
  logic [NE*W-1:0]  data_v;
  logic [NP-1:0]    ready_v, valid_o;
  logic [NP*W-1:0]  pdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NP-1:0]   exp_valid;
  logic [NP*W-1:0] exp_data;
  logic [NE-1:0]   exp_clear;

  qpd_dispatch #(.NP(NP), .NE(NE), .W(W), .IW(IW)) dut (
    .ent_alloc_i  (alloc_v),
    .ent_pvalid_i (pval_v),
    .ent_port_i   (port_v),
    .ent_data_i   (data_v),
    .head_oh_i    (head_v),
    .prt_ready_i  (ready_v),
    .prt_data_o   (pdata_o),
    .prt_valid_o  (valid_o),
    .ent_clear_o  (clear_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: walk from the head by distance, first matching occupied slot wins.
  task automatic model();
    int h;
    h = 0;
    for (int i = 0; i < NE; i++) if (head_v[i]) h = i;
    exp_valid = '0;
    exp_data  = '0;
    exp_clear = '0;
    for (int p = 0; p < NP; p++) begin
      int win;
      win = -1;
      for (int k = 0; k < NE; k++) begin
        int e;
        e = (h + k) % NE;
        if (win < 0 && alloc_v[e] && int'(port_v[e*IW +: IW]) == p) win = e;
      end
      if (win >= 0) begin
        exp_data[p*W +: W] = data_v[win*W +: W];
        exp_valid[p]       = pval_v[win];
        if (pval_v[win] && ready_v[p]) exp_clear[win] = 1'b1;
      end
    end
  endtask

  task automatic settle_and_compare(input string tag);
    #3;
    model();
    chk(valid_o == exp_valid, tag, "valid", 64'(valid_o), 64'(exp_valid));
    chk(pdata_o == exp_data,  tag, "data",  64'(pdata_o), 64'(exp_data));
    chk(clear_o == exp_clear, tag, "clear", 64'(clear_o), 64'(exp_clear));
  endtask

  task automatic clear_all();
    @(negedge clk);
    alloc_v = '0; pval_v = '0; head_v = 8'b1; port_v = '0; data_v = '0; ready_v = '0;
  endtask

  task automatic set_ent(input int e, input bit a, input bit v, input int prt, input logic [W-1:0] d);
    alloc_v[e] = a;
    pval_v[e]  = v;
    port_v[e*IW +: IW] = IW'(prt);
    data_v[e*W +: W]   = d;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    alloc_v = '0; pval_v = '0; head_v = '0; port_v = '0; data_v = '0; ready_v = '0;

    // R7 R2 R4: idle inputs give quiet outputs at once
    #3;
    chk(valid_o == '0 && pdata_o == '0 && clear_o == '0, "R7", "idle outputs",
        64'({valid_o, pdata_o, clear_o}), 64'(0));

    // Worked scenario: head 1, slots 1..3 occupied, ports 1,2,0,2
    clear_all();
    head_v = 8'b0000_0010;
    set_ent(0, 0, 0, 1, 8'hAA);
    set_ent(1, 1, 1, 2, 8'hFF);
    set_ent(2, 1, 1, 0, 8'h11);
    set_ent(3, 1, 0, 2, 8'h77);
    ready_v = 3'b110;
    #3;
    chk(valid_o == 3'b101, "R5", "scenario valid", 64'(valid_o), 64'(3'b101));
    chk(pdata_o == 24'hFF_00_11, "R4", "scenario data", 64'(pdata_o), 64'(24'hFF_00_11));
    chk(clear_o == 8'b0000_0010, "R6", "scenario clear", 64'(clear_o), 64'(8'b10));
    settle_and_compare("R3");

    // R1: out-of-range port number is never served
    clear_all();
    set_ent(0, 1, 1, 3, 8'h5A);
    ready_v = '1;
    #3;
    chk(valid_o == '0 && clear_o == '0 && pdata_o == '0, "R1", "out-of-range slot",
        64'({valid_o, clear_o}), 64'(0));

    // R3: wrap, head at 6, slots 2 and 7 on port 1 -> slot 7 wins
    clear_all();
    head_v = 8'b0100_0000;
    set_ent(2, 1, 1, 1, 8'h22);
    set_ent(7, 1, 1, 1, 8'h77);
    ready_v = 3'b010;
    #3;
    chk(pdata_o[W +: W] == 8'h77, "R3", "wrap winner data", 64'(pdata_o[W +: W]), 64'(8'h77));
    chk(clear_o == 8'b1000_0000, "R3", "wrap winner clear", 64'(clear_o), 64'(8'h80));

    // R5: oldest not ready, younger ready slot must not be offered
    clear_all();
    head_v = 8'b0000_0010;
    set_ent(1, 1, 0, 0, 8'h31);
    set_ent(2, 1, 1, 0, 8'h32);
    ready_v = '1;
    #3;
    chk(valid_o[0] == 1'b0, "R5", "no skip valid", 64'(valid_o), 64'(0));
    chk(pdata_o[0 +: W] == 8'h31, "R5", "stalled data", 64'(pdata_o[0 +: W]), 64'(8'h31));
    chk(clear_o == '0, "R5", "no skip clear", 64'(clear_o), 64'(0));

    // R6: consumer not accepting -> offered but not cleared
    clear_all();
    set_ent(4, 1, 1, 2, 8'h44);
    ready_v = 3'b011;
    #3;
    chk(valid_o == 3'b100 && clear_o == '0, "R6", "held without ready",
        64'({valid_o, clear_o}), 64'({3'b100, 8'h00}));

    // R2: unoccupied slot with ready result is ignored
    clear_all();
    set_ent(5, 0, 1, 1, 8'h55);
    ready_v = '1;
    #3;
    chk(valid_o == '0 && clear_o == '0 && pdata_o == '0, "R2", "unoccupied slot",
        64'({valid_o, clear_o}), 64'(0));

    // Random vectors against the reference model (R1..R6)
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      head_v  = NE'(1) << ($urandom % NE);
      alloc_v = NE'($urandom);
      pval_v  = NE'($urandom) | ((n % 4 == 0) ? NE'($urandom) : '0);
      port_v  = (NE*IW)'($urandom);
      data_v  = {$urandom, $urandom};
      ready_v = NP'($urandom);
      settle_and_compare("R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule